// File: doc/BRIEF.md
# Differential Serial-Audio Frame Splitter

This block takes a two-channel serial audio stream in the common I2S arrangement and produces two serial outputs, one for each of a pair of time-multiplexed converters that are to run differentially. Inside each word-select period, the input carries the left word while word select is low and the right word while it is high. Each output keeps that slot structure but fills both slots from one channel. The low slot holds the word itself. The high slot holds its bitwise complement.

The module runs on the serial bit clock. The input pins are registered once and then feed a chain of two shift-register delay stages, each half a frame deep. A small slot multiplexer chooses, for every bit, between the live bit, the half-frame-old bit and the full-frame-old bit, and inverts the chosen bit where needed. The outputs are registered.

Output A carries the left word of the current frame followed by its complement. Output B carries the right word of the previous frame followed by its complement. Word select passes through with the same latency as the data. A converter that latches at the end of each word-select period therefore sees a matched pair in both slots.

Top module: `ifs_splitter`

## Requirements
- R1: While reset is asserted, `ws_out`, `sd_a` and `sd_b` are 0, and every delay stage is cleared to 0.
- R2: `ws_out` equals the `ws_in` value sampled two rising `clk` edges earlier.
- R3: When the word select driving the output stage (the `ws_in` sampled two edges back) is 0, `sd_a` equals the `sd_in` bit sampled two edges earlier.
- R4: When that word select is 1, `sd_a` equals the inverse of the `sd_in` bit sampled 2+H edges earlier, where H = FRAME_BITS/2.
- R5: When that word select is 0, `sd_b` equals the `sd_in` bit sampled 2+H edges earlier, without inversion.
- R6: When that word select is 1, `sd_b` equals the inverse of the `sd_in` bit sampled 2+2H edges earlier.
- R7: FRAME_BITS may be 64 or 32. Each delay stage is exactly FRAME_BITS/2 bits deep, so R3 to R6 hold for both sizes.
- R8: Until a delay stage has filled after reset, it yields 0. A slot that takes an inverted bit from the unfilled region therefore drives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ws_in | input | 1 | Word select: 0 = left slot, 1 = right slot |
| sd_in | input | 1 | Serial data, two's-complement words MSB first |
| ws_out | output | 1 | Word select delayed to match the output data |
| sd_a | output | 1 | Left word, then its bitwise inverse |
| sd_b | output | 1 | Right word of the previous frame, then its bitwise inverse |

## Verification
The bench goes after the three tap distances. If a delay stage were one bit too short or too long, every inverted bit would be shifted by a bit position, and the per-bit comparison would fail on the first random word. If output B took its second slot from the half-frame tap instead of the full-frame tap, it would invert the left word rather than the right one. If the inversion were missing or put in the wrong slot, the extreme words 0x8000, 0x7FFF, 0xFFFF and 0x0000 would expose it at once. Both frame sizes run side by side, and the first frames after reset check that unfilled delay contents come out as 0, and as 1 where inverted.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  // Which half of a word-select period the output stage is filling.
  typedef enum logic {
    SLOT_DIRECT = 1'b0,
    SLOT_MIRROR = 1'b1
  } slot_e;

  localparam int unsigned IFS_DELAY_STAGES = 2;
endpackage

// File: rtl/ifs_rst_sync.sv
module ifs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[1];
endmodule

// File: rtl/ifs_half_delay.sv
module ifs_half_delay #(
  parameter int unsigned DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] sr_d;

  always_comb sr_d = {sr_q[DEPTH-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign q = sr_q[DEPTH-1];
endmodule

// File: rtl/ifs_slot_mux.sv
module ifs_slot_mux
  import ifs_pkg::*;
(
  input  slot_e slot,
  input  logic  live,
  input  logic  half_old,
  input  logic  full_old,
  output logic  a_nxt,
  output logic  b_nxt
);
  always_comb begin
    unique case (slot)
      SLOT_DIRECT: begin
        a_nxt = live;
        b_nxt = half_old;
      end
      SLOT_MIRROR: begin
        a_nxt = ~half_old;
        b_nxt = ~full_old;
      end
      default: begin
        a_nxt = 1'b0;
        b_nxt = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ifs_splitter.sv
module ifs_splitter
  import ifs_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ws_in,
  input  logic sd_in,
  output logic ws_out,
  output logic sd_a,
  output logic sd_b
);
  localparam int unsigned HALF = FRAME_BITS / 2;
  localparam int unsigned NSTG = IFS_DELAY_STAGES;

  logic rst_q_n;
  logic ws_r, sd_r;
  logic ws_q, a_q, b_q;
  logic a_nxt, b_nxt;
  logic tap [0:NSTG];

  ifs_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  // input capture
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ws_r <= 1'b0;
      sd_r <= 1'b0;
    end else begin
      ws_r <= ws_in;
      sd_r <= sd_in;
    end
  end

  assign tap[0] = sd_r;

  // cascade of half-frame delay stages: tap[g] is g half-frames old
  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    ifs_half_delay #(.DEPTH(HALF)) u_dly (
      .clk   (clk),
      .rst_n (rst_q_n),
      .d     (tap[g]),
      .q     (tap[g+1])
    );
  end

  ifs_slot_mux u_mux (
    .slot     (slot_e'(ws_r)),
    .live     (tap[0]),
    .half_old (tap[1]),
    .full_old (tap[2]),
    .a_nxt    (a_nxt),
    .b_nxt    (b_nxt)
  );

  // output stage
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ws_q <= 1'b0;
      a_q  <= 1'b0;
      b_q  <= 1'b0;
    end else begin
      ws_q <= ws_r;
      a_q  <= a_nxt;
      b_q  <= b_nxt;
    end
  end

  assign ws_out = ws_q;
  assign sd_a   = a_q;
  assign sd_b   = b_q;
endmodule

// File: rtl/ifs_split_chk.sv
module ifs_split_chk (
  input logic clk,
  input logic rst_q_n,
  input logic ws_in,
  input logic sd_in,
  input logic ws_out,
  input logic sd_a,
  input logic sd_b,
  input logic dly1,
  input logic dly2
);
  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)          warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R2
  ws_latency_chk: assert property (@(posedge clk) disable iff (!rst_q_n || warm != 2'd3)
    ws_out == $past(ws_in, 2));

  // R3
  a_direct_chk: assert property (@(posedge clk) disable iff (!rst_q_n || warm != 2'd3)
    !ws_out |-> (sd_a == $past(sd_in, 2)));

  // R4
  a_mirror_chk: assert property (@(posedge clk) disable iff (!rst_q_n || warm != 2'd3)
    ws_out |-> (sd_a == ~$past(dly1)));

  // R5
  b_direct_chk: assert property (@(posedge clk) disable iff (!rst_q_n || warm != 2'd3)
    !ws_out |-> (sd_b == $past(dly1)));

  // R6
  b_mirror_chk: assert property (@(posedge clk) disable iff (!rst_q_n || warm != 2'd3)
    ws_out |-> (sd_b == ~$past(dly2)));
endmodule

bind ifs_splitter ifs_split_chk u_chk (
  .clk     (clk),
  .rst_q_n (rst_q_n),
  .ws_in   (ws_in),
  .sd_in   (sd_in),
  .ws_out  (ws_out),
  .sd_a    (sd_a),
  .sd_b    (sd_b),
  .dly1    (tap[1]),
  .dly2    (tap[2])
);

// File: tb/sim_ifs_splitter.sv
`timescale 1ns/1ps
module sim_ifs_splitter;
  localparam int START  = 10;
  localparam int NFRM   = 60;
  localparam int NCYC   = START + 64 * NFRM + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ws64 = 1'b0, ws32 = 1'b0, sd = 1'b0;
  logic ws_o0, a0, b0, ws_o1, a1, b1;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic hw64[$];
  logic hw32[$];
  logic hx[$];

  always #2 clk = ~clk;

  ifs_splitter #(.FRAME_BITS(64)) u0 (
    .clk(clk), .rst_n(rst_n), .ws_in(ws64), .sd_in(sd),
    .ws_out(ws_o0), .sd_a(a0), .sd_b(b0));

  ifs_splitter #(.FRAME_BITS(32)) u1 (
    .clk(clk), .rst_n(rst_n), .ws_in(ws32), .sd_in(sd),
    .ws_out(ws_o1), .sd_a(a1), .sd_b(b1));

  function automatic logic getq(ref logic q[$], input int i);
    if (i < 0 || i >= q.size()) return 1'b0;
    return q[i];
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input int n);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, n, act, exp);
    end
  endtask

  // Compare one instance against the reference built from the input history.
  task automatic cmp(input int h, input int n, input logic w_o, input logic a, input logic b,
                     input string pre);
    int  i;
    logic w, ea, eb;
    string ta, tb;
    i  = n - 2;
    w  = (h == 32) ? getq(hw64, i) : getq(hw32, i);
    ea = w ? ~getq(hx, i - h) : getq(hx, i);
    eb = w ? ~getq(hx, i - 2*h) : getq(hx, i - h);
    ta = w ? "R4" : "R3";
    tb = w ? "R6" : "R5";
    if (w && (i - h) < START)       ta = "R8 R4";
    if (!w && (i - h) < START)      tb = "R8 R5";
    if (w && (i - 2*h) < START)     tb = "R8 R6";
    chk({pre, "R2"}, w_o, w, n);
    chk({pre, ta}, a, ea, n);
    chk({pre, tb}, b, eb, n);
  endtask

  function automatic logic slot_bit(input int p, input int half, input logic [15:0] s);
    // p = position within slot, MSB one bit after the word-select change
    if (p >= 1 && p <= 16) return s[16 - p];
    return 1'b0;
  endfunction

  initial begin
    logic [15:0] l_s, r_s;
    for (int n = 0; n < NCYC; n++) begin
      @(negedge clk);
      if (n >= 2) begin
        cmp(32, n, ws_o0, a0, b0, "");
        cmp(16, n, ws_o1, a1, b1, "R7 ");
      end
      if (n == 3) begin
        // R1: outputs held at 0 during reset
        chk("R1", ws_o0 | a0 | b0 | ws_o1 | a1 | b1, 1'b0, n);
      end
      if (n == 5) rst_n = 1'b1;
      if (n < START) begin
        ws64 = 1'b0; ws32 = 1'b0; sd = 1'b0;
      end else begin
        int ph64, ph32;
        ph64 = (n - START) % 64;
        ph32 = (n - START) % 32;
        if (ph64 == 0) begin
          case ((n - START) / 64)
            0: begin l_s = 16'h8000; r_s = 16'h7FFF; end
            1: begin l_s = 16'hFFFF; r_s = 16'h0000; end
            default: begin l_s = 16'($urandom); r_s = 16'($urandom); end
          endcase
        end
        ws64 = (ph64 >= 32);
        ws32 = (ph32 >= 16);
        sd   = ws64 ? slot_bit(ph64 - 32, 32, r_s) : slot_bit(ph64, 32, l_s);
      end
      hw64.push_back(ws64);
      hw32.push_back(ws32);
      hx.push_back(sd);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule